// File: doc/BRIEF.md
# Three-Wire Radio Register Serial Master

This block drives the register port of an external radio front end over three wires: an enable strobe, a serial clock and a bidirectional data line, plus a read/write flag line. A host hands it one register access at a time through a valid/ready handshake that carries a read/write flag, an address and write data. The block builds the serial frame and shifts it out. For a read it turns the data line around, clocks in the value the radio returns, and hands that value back with a one-cycle done pulse.

Every frame is a fixed series of timing units. The length of one unit comes from a prescaler value supplied by the host. The same sequence therefore gives the microsecond-scale setup, hold and strobe times at any system clock rate. Write frames pack two data bits into each serial clock period. Read frames send a short address header at one bit per clock period and then read twelve bits.

Top module: `rf3w_master`

## Requirements
- R1: Out of reset and between frames the pins rest at enable=0, clock=0, data=0, data output enable=1 and read/write flag=0, with req_ready_o=1 and done_o=0.
- R2: A request is taken only on a clock edge where req_valid_i and req_ready_o are both high. req_ready_o stays low from that edge until the frame has finished, and requests offered meanwhile have no effect on the pins.
- R3: Each timing unit lasts presc_i+1 clock cycles, and the first unit begins on the cycle after acceptance.
- R4: Each frame opens with enable high for PULSE_UNITS units (default 2). Enable then goes low for SETTLE_UNITS units (default 4), with the clock and data low throughout.
- R5: A write sends a 16-bit word: write data in bits 15..4 and the low four address bits in bits 3..0. The word goes out most significant bit first.
- R6: Write bits go in pairs of four units each. Unit 0 drives the first bit with clock low, unit 1 keeps it with clock high, unit 2 drives the second bit with clock still high, and unit 3 keeps the second bit with clock low.
- R7: A read sends the 5-bit address most significant bit first, two units per bit: clock low and then clock high, with the data pin driven.
- R8: After the read address, one turnaround unit releases the data pin (output enable 0) and raises the read/write flag, with clock low. Both stay in that condition until the frame ends.
- R9: A read then clocks 12 bits, each as a low unit followed by a high unit. data_i is sampled at the end of the high unit, and the first sample is the most significant bit.
- R10: Every frame closes with enable high and clock low for SETTLE_UNITS units. A read keeps the flag high and the pin released during this phase. Then the idle pin state of R1 returns.
- R11: At the end of a read, done_o is high for exactly one cycle (the first idle cycle) and rdata_o carries the captured value. Writes produce no done pulse.
- R12: The serial clock is never high while enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_i | input | 8 | Timing unit length minus one, in clock cycles |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_addr_i | input | 5 | Register address (writes use bits 3..0) |
| req_data_i | input | 12 | Write data |
| done_o | output | 1 | One-cycle pulse at read completion |
| rdata_o | output | 12 | Value read from the radio |
| sen_o | output | 1 | Serial enable strobe |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data out |
| sdata_oe_o | output | 1 | Data pin output enable |
| sdata_i | input | 1 | Serial data in |
| rw_o | output | 1 | Read/write flag line |

## Verification
The bench checks every unit of every frame, at its first and last cycle, against a pin pattern derived from the frame definition. It does this for all write addresses and all read addresses, with prescaler settings of 0 to 3. A design that swaps the two bits of a write pair, or toggles the clock once per bit, fails in the write data phase. A unit that is one cycle long or short shows up as a mismatch at the edge of a unit. The radio model returns a different word for each read, so sampling on the wrong half of the clock, or in LSB-first order, produces a wrong rdata_o. Requests offered in the middle of a frame, a done pulse after a write, and a pin that is still released after a read are all checked directly.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PULSE, ST_GAP, ST_WBITS, ST_RADDR, ST_TURN, ST_RBITS, ST_FINISH
  } rf3w_state_e;
endpackage

// File: rtl/rf3w_tick.sv
module rf3w_tick #(
  parameter int PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = busy_i && (cnt_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!busy_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R3: first unit of a frame starts from a clean count
  a_r3_start_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (cnt_q == '0));
endmodule

// File: rtl/rf3w_seq.sv
module rf3w_seq
  import rf3w_pkg::*;
#(
  parameter int PULSE_UNITS  = 2,
  parameter int SETTLE_UNITS = 4,
  parameter int WFRAME_W     = 16,
  parameter int RADDR_W      = 5,
  parameter int RDATA_W      = 12,
  parameter int WDATA_W      = 12,
  parameter int IDX_W        = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [RADDR_W-1:0] req_addr_i,
  input  logic [WDATA_W-1:0] req_data_i,
  output logic               req_ready_o,
  output rf3w_state_e        state_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               last_o,
  output logic               is_write_o,
  output logic [RADDR_W-1:0] addr_o,
  output logic [WDATA_W-1:0] data_o
);
  rf3w_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, len;
  logic             fire;

  assign req_ready_o = (state_q == ST_IDLE);
  assign fire        = req_valid_i && req_ready_o;

  always_comb begin
    unique case (state_q)
      ST_PULSE:  len = IDX_W'(PULSE_UNITS);
      ST_GAP:    len = IDX_W'(SETTLE_UNITS);
      ST_WBITS:  len = IDX_W'(2 * WFRAME_W);
      ST_RADDR:  len = IDX_W'(2 * RADDR_W);
      ST_TURN:   len = IDX_W'(1);
      ST_RBITS:  len = IDX_W'(2 * RDATA_W);
      ST_FINISH: len = IDX_W'(SETTLE_UNITS);
      default:   len = IDX_W'(1);
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_PULSE:  state_d = ST_GAP;
      ST_GAP:    state_d = is_write_o ? ST_WBITS : ST_RADDR;
      ST_WBITS:  state_d = ST_FINISH;
      ST_RADDR:  state_d = ST_TURN;
      ST_TURN:   state_d = ST_RBITS;
      ST_RBITS:  state_d = ST_FINISH;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign last_o = tick_i && (idx_q == len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      is_write_o <= 1'b0;
      addr_o     <= '0;
      data_o     <= '0;
    end else if (state_q == ST_IDLE) begin
      if (fire) begin
        state_q    <= ST_PULSE;
        idx_q      <= '0;
        is_write_o <= req_write_i;
        addr_o     <= req_addr_i;
        data_o     <= req_data_i;
      end
    end else if (tick_i) begin
      if (last_o) begin
        state_q <= state_d;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  // R2: an accepted request always opens with the enable pulse
  a_r2_fire_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (state_q == ST_PULSE));
  // R3: unit index stays inside the current phase
  a_r3_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (idx_q < len));
endmodule

// File: rtl/rf3w_pins.sv
module rf3w_pins
  import rf3w_pkg::*;
#(
  parameter int WFRAME_W = 16,
  parameter int WADDR_W  = 4,
  parameter int WDATA_W  = 12,
  parameter int RADDR_W  = 5,
  parameter int IDX_W    = 6
) (
  input  rf3w_state_e        state_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               is_write_i,
  input  logic [RADDR_W-1:0] addr_i,
  input  logic [WDATA_W-1:0] data_i,
  output logic               sen_o,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               oe_o,
  output logic               rw_o
);
  logic [WFRAME_W-1:0] wframe, wsh;
  logic [RADDR_W-1:0]  ash;

  assign wframe = {data_i, addr_i[WADDR_W-1:0]};
  // unit idx = 4*pair + phase; bit offset = 2*pair + phase[1]
  assign wsh    = wframe << {idx_i[IDX_W-1:2], idx_i[1]};
  assign ash    = addr_i << idx_i[IDX_W-1:1];

  always_comb begin
    sen_o   = 1'b0;
    sclk_o  = 1'b0;
    sdata_o = 1'b0;
    oe_o    = 1'b1;
    rw_o    = 1'b0;
    unique case (state_i)
      ST_PULSE: sen_o = 1'b1;
      ST_WBITS: begin
        sclk_o  = idx_i[1] ^ idx_i[0];
        sdata_o = wsh[WFRAME_W-1];
      end
      ST_RADDR: begin
        sclk_o  = idx_i[0];
        sdata_o = ash[RADDR_W-1];
      end
      ST_TURN: begin
        oe_o = 1'b0;
        rw_o = 1'b1;
      end
      ST_RBITS: begin
        sclk_o = idx_i[0];
        oe_o   = 1'b0;
        rw_o   = 1'b1;
      end
      ST_FINISH: begin
        sen_o = 1'b1;
        oe_o  = is_write_i;
        rw_o  = !is_write_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rf3w_capture.sv
module rf3w_capture #(
  parameter int RDATA_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic               finish_i,
  input  logic               sdata_i,
  output logic               done_o,
  output logic [RDATA_W-1:0] rdata_o
);
  logic [RDATA_W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      if (sample_i) cap_q <= {cap_q[RDATA_W-2:0], sdata_i};
      if (finish_i) rdata_o <= cap_q;
      done_o <= finish_i;
    end
  end

  // R11: completion is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/rf3w_master.sv
module rf3w_master
  import rf3w_pkg::*;
#(
  parameter int PRESC_W      = 8,
  parameter int PULSE_UNITS  = 2,
  parameter int SETTLE_UNITS = 4,
  parameter int WADDR_W      = 4,
  parameter int WDATA_W      = 12,
  parameter int RADDR_W      = 5,
  parameter int RDATA_W      = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [RADDR_W-1:0] req_addr_i,
  input  logic [WDATA_W-1:0] req_data_i,
  output logic               done_o,
  output logic [RDATA_W-1:0] rdata_o,
  output logic               sen_o,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               sdata_oe_o,
  input  logic               sdata_i,
  output logic               rw_o
);
  localparam int WFRAME_W = WDATA_W + WADDR_W;
  localparam int MAXLEN_A = (2 * WFRAME_W > 2 * RDATA_W) ? 2 * WFRAME_W : 2 * RDATA_W;
  localparam int MAXLEN_B = (PULSE_UNITS > SETTLE_UNITS) ? PULSE_UNITS : SETTLE_UNITS;
  localparam int MAXLEN   = (MAXLEN_A > MAXLEN_B) ? MAXLEN_A : MAXLEN_B;
  localparam int IDX_W    = $clog2(MAXLEN + 1) < 3 ? 3 : $clog2(MAXLEN + 1);

  rf3w_state_e        state;
  logic [IDX_W-1:0]   idx;
  logic               tick, last, is_write, busy;
  logic [RADDR_W-1:0] addr_q;
  logic [WDATA_W-1:0] data_q;

  assign busy = (state != ST_IDLE);

  rf3w_tick #(.PRESC_W(PRESC_W)) u_tick (
    .clk_i, .rst_ni, .busy_i(busy), .presc_i, .tick_o(tick)
  );

  rf3w_seq #(
    .PULSE_UNITS(PULSE_UNITS), .SETTLE_UNITS(SETTLE_UNITS), .WFRAME_W(WFRAME_W),
    .RADDR_W(RADDR_W), .RDATA_W(RDATA_W), .WDATA_W(WDATA_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .req_valid_i, .req_write_i, .req_addr_i,
    .req_data_i, .req_ready_o, .state_o(state), .idx_o(idx), .last_o(last),
    .is_write_o(is_write), .addr_o(addr_q), .data_o(data_q)
  );

  rf3w_pins #(
    .WFRAME_W(WFRAME_W), .WADDR_W(WADDR_W), .WDATA_W(WDATA_W),
    .RADDR_W(RADDR_W), .IDX_W(IDX_W)
  ) u_pins (
    .state_i(state), .idx_i(idx), .is_write_i(is_write), .addr_i(addr_q),
    .data_i(data_q), .sen_o, .sclk_o, .sdata_o, .oe_o(sdata_oe_o), .rw_o
  );

  rf3w_capture #(.RDATA_W(RDATA_W)) u_cap (
    .clk_i, .rst_ni,
    .sample_i(tick && (state == ST_RBITS) && idx[0]),
    .finish_i(last && (state == ST_FINISH) && !is_write),
    .sdata_i, .done_o, .rdata_o
  );

  // R8: the pin is only ever released with the flag raised
  a_r8_release_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> rw_o);
  // R12: no clock edge while the strobe is high
  a_r12_sclk_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_o |-> !sclk_o);
  // R5: a write frame never releases the data pin
  a_r5_write_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && is_write) |-> sdata_oe_o);
  // R10: the flag drops only when returning to idle
  a_r10_flag_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rw_o) |-> req_ready_o);
endmodule

// File: tb/rf3w_master_tb.sv
module rf3w_master_tb_top;
  localparam int P = 2;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  presc = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [11:0] req_data = '0;
  logic        req_ready, done, sen, sclk, sdata, sdata_oe, rw;
  logic        sdata_in = 1'b0;
  logic [11:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rf3w_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .presc_i(presc), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_data_i(req_data), .done_o(done), .rdata_o(rdata), .sen_o(sen),
    .sclk_o(sclk), .sdata_o(sdata), .sdata_oe_o(sdata_oe), .sdata_i(sdata_in),
    .rw_o(rw)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // pin vector {sen, sclk, sdata, oe, rw}
  function automatic logic [4:0] exp_pins(bit wr, logic [15:0] fr, logic [4:0] ad, int unit);
    int u = unit;
    int k;
    if (u < P) return 5'b10010;
    u -= P;
    if (u < S) return 5'b00010;
    u -= S;
    if (wr) begin
      if (u < 32) begin
        k = u / 4;
        if (u % 4 < 2) return {1'b0, (u % 4) == 1, fr[15 - 2*k], 2'b10};
        return {1'b0, (u % 4) == 2, fr[14 - 2*k], 2'b10};
      end
      return 5'b10010;
    end
    if (u < 10) return {1'b0, (u % 2) == 1, ad[4 - u/2], 2'b10};
    u -= 10;
    if (u < 1) return 5'b00001;
    u -= 1;
    if (u < 24) return {1'b0, (u % 2) == 1, 3'b001};
    return 5'b10001;
  endfunction

  function automatic string unit_tag(bit wr, int u);
    if (u < P + S) return "R4";
    if (wr) return (u < P + S + 32) ? "R6/R5" : "R10";
    if (u < P + S + 10) return "R7";
    if (u < P + S + 11) return "R8";
    if (u < P + S + 35) return "R9";
    return "R10";
  endfunction

  task automatic run_frame(input bit wr, input logic [4:0] ad, input logic [11:0] dat,
                           input logic [11:0] rval, input int pr, input bit poke);
    int n_units = wr ? (P + S + 32 + S) : (P + S + 35 + S);
    int L = pr + 1;
    logic [15:0] fr = {dat, ad[3:0]};
    logic [4:0] got, exp;
    @(negedge clk);
    presc = 8'(pr);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_data = dat;
    chk(req_ready == 1'b1, "R1 ready before frame", 32'(req_ready), 1);
    @(posedge clk);
    for (int u = 0; u < n_units; u++) begin
      for (int c = 0; c < L; c++) begin
        @(negedge clk);
        if (u == 0 && c == 0) req_valid = 1'b0;
        if (c == 0 && !wr && u >= P + S + 11 && u < P + S + 35 && ((u - P - S - 11) % 2 == 0))
          sdata_in = rval[11 - (u - P - S - 11) / 2];
        if (poke && c == 0 && u == 5) begin
          req_valid = 1'b1; req_write = !wr; req_addr = ~ad; req_data = ~dat;
        end
        if (poke && c == 0 && u == 8) req_valid = 1'b0;
        if (c == 0 || c == L - 1) begin
          got = {sen, sclk, sdata, sdata_oe, rw};
          exp = exp_pins(wr, fr, ad, u);
          chk(got == exp, $sformatf("%s/R3 unit %0d cycle %0d", unit_tag(wr, u), u, c),
              32'(got), 32'(exp));
          chk(req_ready == 1'b0, "R2 ready low while busy", 32'(req_ready), 0);
          chk(done == 1'b0, "R11 no done mid-frame", 32'(done), 0);
        end
      end
    end
    @(negedge clk);
    got = {sen, sclk, sdata, sdata_oe, rw};
    chk(got == 5'b00010, "R10/R1 idle pins after frame", 32'(got), 32'h02);
    chk(req_ready == 1'b1, "R2 ready after frame", 32'(req_ready), 1);
    if (wr) begin
      chk(done == 1'b0, "R11 no done for write", 32'(done), 0);
    end else begin
      chk(done == 1'b1, "R11 done on read", 32'(done), 1);
      chk(rdata == rval, "R9/R11 read data", 32'(rdata), 32'(rval));
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done lasts one cycle", 32'(done), 0);
    chk(sen == 1'b0 && req_ready == 1'b1, "R2 poked request not taken",
        32'({sen, req_ready}), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({sen, sclk, sdata, sdata_oe, rw} == 5'b00010, "R1 reset pins",
        32'({sen, sclk, sdata, sdata_oe, rw}), 32'h02);
    chk(req_ready == 1'b1 && done == 1'b0, "R1 reset handshake",
        32'({req_ready, done}), 32'h2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({sen, sclk, sdata, sdata_oe, rw} == 5'b00010, "R1 idle after reset",
        32'({sen, sclk, sdata, sdata_oe, rw}), 32'h02);

    // R5 R6: every write address, assorted data
    for (int a = 0; a < 16; a++)
      run_frame(1'b1, 5'(a | ((a & 1) << 4)), 12'((a * 273 + 12'h5a3) & 12'hfff),
                12'h0, a % 4, (a % 3) == 1);
    run_frame(1'b1, 5'h0f, 12'hfff, 12'h0, 0, 1'b0);
    run_frame(1'b1, 5'h00, 12'h000, 12'h0, 2, 1'b0);
    run_frame(1'b1, 5'h05, 12'haaa, 12'h0, 1, 1'b0);

    // R7 R8 R9: every read address, distinct return words
    for (int a = 0; a < 32; a++)
      run_frame(1'b0, 5'(a), 12'(~a), 12'((a * 12'h09e + 12'h3c5) & 12'hfff),
                a % 3, (a % 4) == 2);
    run_frame(1'b0, 5'h15, 12'h0, 12'hfff, 0, 1'b0);
    run_frame(1'b0, 5'h0a, 12'h0, 12'h800, 3, 1'b0);
    run_frame(1'b0, 5'h1f, 12'h0, 12'h001, 1, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule